// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Multiplier

This block multiplies two 17-bit floating-point operands in one combinational pass. Each operand holds a sign bit, an 8-bit exponent with a bias of 127 and an 8-bit fraction whose leading 1 is implied. The result sign comes from an exclusive-OR of the operand signs. The exponents are summed and one bias is removed. The two 9-bit significands go through an unsigned integer multiplier core. That core recodes the multiplier in radix 4, compresses the rows in carry-save form and finishes with a ripple adder. The 18-bit product is then normalised by at most one place.

The block has no clock and no state. Each result falls into one of four named classes, and the output stage picks the packed word and flags from that class. Class `CLS_ZERO` applies when either operand has a zero exponent field. Class `CLS_OVF` applies when the adjusted exponent reaches 255 or more. Class `CLS_UNF` applies when the adjusted exponent falls to 0 or below. Class `CLS_NORMAL` covers every other case. The selection between classes is by priority in the order zero, overflow, underflow, normal. There are no transitions, because each result depends only on the present inputs. Denormals, NaN, infinity and rounding are not handled. The fraction is truncated.

Top module: `rp_fp_mul`

## Requirements
- R1: Result bit 16 equals the exclusive-OR of operand bits 16, for every class.
- R2: Packed words place the sign at bit 16, the biased exponent at bits 15:8 and the fraction at bits 7:0. For example, 1.0 times 1.0 gives 17'h07F00.
- R3: With P the product of the significands {1, fraction}, when P bit 17 is clear the result fraction is P[15:8] and the result exponent is Ea + Eb - 127.
- R4: When P bit 17 is set, the result fraction is P[16:9] and the result exponent is Ea + Eb - 126.
- R5: Product bits below the kept fraction are discarded without rounding. For example, 1.50390625 squared gives fraction 8'h21, not 8'h22.
- R6: When the adjusted exponent is 255 or more, the overflow flag is 1 and the result is the signed largest finite value, exponent 8'hFE and fraction 8'hFF.
- R7: When the adjusted exponent is 0 or less, the underflow flag is 1 and the result is a signed zero, with exponent and fraction both 0.
- R8: When either operand has an exponent field of 0, the result is a signed zero with both flags 0, whatever the other operand holds.
- R9: The two flags are never 1 together, and both are 0 for a normal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 17 | First operand, packed sign/exponent/fraction |
| b_i | input | 17 | Second operand, packed sign/exponent/fraction |
| res_o | output | 17 | Packed product |
| ovf_o | output | 1 | Exponent overflow; the result is saturated |
| unf_o | output | 1 | Exponent underflow; the result is flushed to zero |

## Verification
Significands of 1.0 and 1.5 separate the two normalisation paths, because only the second carries the product into bit 17. A fraction of 8'h81 squared leaves more than half an LSB in the discarded bits, so a rounding design would give a different answer. Exponent pairs that sum to 254 and then 255 after the normalisation increment test the overflow boundary. Pairs that give 0 and then 1 test the underflow boundary. A zero-exponent operand paired with a huge one tells a signed zero apart from an underflow through the flags. Several hundred arbitrary operand pairs are then checked against an integer model.

// File: rtl/rp_fp_mul_pkg.sv
package rp_fp_mul_pkg;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_OVF    = 2'd2,
        CLS_UNF    = 2'd3
    } res_class_e;

endpackage

// File: rtl/rp_radix4_digit.sv
// Recodes one overlapping bit triple of the multiplier into a signed digit
// in {-2,-1,0,+1,+2}, as a magnitude select (one/two) and a negate flag.
module rp_radix4_digit (
    input  logic [2:0] trip_i,
    output logic       one_o,
    output logic       two_o,
    output logic       neg_o
);
    always_comb begin
        one_o = trip_i[1] ^ trip_i[0];
        two_o = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                (~trip_i[2] & trip_i[1] & trip_i[0]);
        // an all-ones triple is a zero digit, so it must not negate
        neg_o = trip_i[2] & ~(trip_i[1] & trip_i[0]);
    end
endmodule

// File: rtl/rp_csa_row.sv
// One row of 3:2 carry-save compression across W bit columns.
module rp_csa_row #(
    parameter int W = 18
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] car_o
);
    logic [W-2:0] maj;

    always_comb begin
        sum_o = x_i ^ y_i ^ z_i;
        maj   = (x_i[W-2:0] & y_i[W-2:0]) |
                (x_i[W-2:0] & z_i[W-2:0]) |
                (y_i[W-2:0] & z_i[W-2:0]);
        car_o = {maj, 1'b0};
    end
endmodule

// File: rtl/rp_sig_mult.sv
// Unsigned SIG_W x SIG_W integer multiplier core: radix-4 recoded rows,
// a carry-save chain and a ripple carry final adder.
module rp_sig_mult #(
    parameter int SIG_W = 9
) (
    input  logic [SIG_W-1:0]   a_i,
    input  logic [SIG_W-1:0]   b_i,
    output logic [2*SIG_W-1:0] prod_o
);
    // pad the multiplier with zeros to an even width so its top digit stays
    // non-negative and the unsigned value is represented exactly
    localparam int EXT_W  = (SIG_W % 2 == 0) ? SIG_W + 2 : SIG_W + 1;
    localparam int DIGITS = EXT_W / 2;
    localparam int ROWS   = DIGITS + 1;   // recoded rows plus the negate row
    localparam int PW     = 2 * SIG_W;    // the product fits, so work modulo 2^PW

    logic [EXT_W:0]  b_ext;
    logic [PW-1:0]   y_ext;
    logic [PW-1:0]   rows [ROWS];
    logic [PW-1:0]   neg_row;
    logic [PW-1:0]   s_stg [ROWS-1];
    logic [PW-1:0]   c_stg [ROWS-1];
    logic [PW-1:0]   cy;
    logic [PW-1:0]   total;

    assign b_ext = {{(EXT_W - SIG_W){1'b0}}, b_i, 1'b0};
    assign y_ext = {{(PW - SIG_W){1'b0}}, a_i};

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_digit
            logic          one, two, neg;
            logic [PW-1:0] mag;
            logic [PW-1:0] sel;

            rp_radix4_digit u_enc (
                .trip_i (b_ext[2*i+2:2*i]),
                .one_o  (one),
                .two_o  (two),
                .neg_o  (neg)
            );

            assign mag = two ? (y_ext << 1) : (one ? y_ext : '0);
            // -M is formed as ~M here plus a 1 injected in the negate row
            assign sel = neg ? ~mag : mag;
            assign rows[i] = sel << (2 * i);
            assign neg_row[2*i]   = neg;
            assign neg_row[2*i+1] = 1'b0;
        end

        if (PW > 2 * DIGITS) begin : g_neg_top
            assign neg_row[PW-1:2*DIGITS] = '0;
        end
    endgenerate

    assign rows[DIGITS] = neg_row;

    // linear carry-save accumulation of the remaining rows
    assign s_stg[0] = rows[0];
    assign c_stg[0] = rows[1];

    generate
        for (genvar j = 0; j < ROWS - 2; j++) begin : g_csa
            rp_csa_row #(.W(PW)) u_csa (
                .x_i   (s_stg[j]),
                .y_i   (c_stg[j]),
                .z_i   (rows[j+2]),
                .sum_o (s_stg[j+1]),
                .car_o (c_stg[j+1])
            );
        end
    endgenerate

    // ripple carry final adder; the carry out of the top column is discarded
    assign cy[0] = 1'b0;
    generate
        for (genvar k = 0; k < PW; k++) begin : g_rca
            assign total[k] = s_stg[ROWS-2][k] ^ c_stg[ROWS-2][k] ^ cy[k];
            if (k < PW - 1) begin : g_cy
                assign cy[k+1] = (s_stg[ROWS-2][k] & c_stg[ROWS-2][k]) |
                                 (cy[k] & (s_stg[ROWS-2][k] ^ c_stg[ROWS-2][k]));
            end
        end
    endgenerate

    assign prod_o = total;

    // R3/R4: two significands with leading ones give a product in [2^(PW-2), 2^PW)
    always_comb begin
        if (a_i[SIG_W-1] && b_i[SIG_W-1]) begin
            assert_prod_lead_R3: assert (prod_o[PW-1] || prod_o[PW-2]);
        end
    end
endmodule

// File: rtl/rp_exp_unit.sv
// Sums the biased exponents, removes one bias, adds the normalisation
// increment and classifies the signed result against the finite range.
module rp_exp_unit #(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W-1:0] ea_i,
    input  logic [EXP_W-1:0] eb_i,
    input  logic             norm_i,
    output logic [EXP_W-1:0] exp_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int RAW_W = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    logic [RAW_W-1:0] raw;

    always_comb begin
        raw = {2'b00, ea_i} + {2'b00, eb_i} + {{(RAW_W-1){1'b0}}, norm_i}
              - RAW_W'(BIAS);
        exp_o = raw[EXP_W-1:0];
        // the sum never reaches the two top bits from below, so a set MSB is negative
        ovf_o = ~raw[RAW_W-1] & (raw[RAW_W-2] | (&raw[EXP_W-1:0]));
        unf_o = raw[RAW_W-1] | (raw == '0);
    end

    always_comb begin
        assert_exp_flags_excl_R9: assert (!(ovf_o && unf_o));
    end
endmodule

// File: rtl/rp_fp_mul.sv
module rp_fp_mul
    import rp_fp_mul_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  ovf_o,
    output logic                  unf_o
);
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam logic [EXP_W-1:0] EXP_SAT = {{(EXP_W-1){1'b1}}, 1'b0};

    logic              sign;
    logic [EXP_W-1:0]  ea, eb, exp_raw;
    logic [SIG_W-1:0]  sig_a, sig_b;
    logic [PROD_W-1:0] prod;
    logic              norm;
    logic [FRAC_W-1:0] frac_n;
    logic              zero_in, e_ovf, e_unf;
    res_class_e        cls;

    assign sign    = a_i[W-1] ^ b_i[W-1];
    assign ea      = a_i[W-2:FRAC_W];
    assign eb      = b_i[W-2:FRAC_W];
    assign sig_a   = {1'b1, a_i[FRAC_W-1:0]};
    assign sig_b   = {1'b1, b_i[FRAC_W-1:0]};
    assign zero_in = (ea == '0) || (eb == '0);

    rp_sig_mult #(.SIG_W(SIG_W)) u_sig_mult (
        .a_i    (sig_a),
        .b_i    (sig_b),
        .prod_o (prod)
    );

    // one-place normalisation; bits below the kept fraction are truncated
    assign norm   = prod[PROD_W-1];
    assign frac_n = norm ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

    rp_exp_unit #(.EXP_W(EXP_W)) u_exp_unit (
        .ea_i   (ea),
        .eb_i   (eb),
        .norm_i (norm),
        .exp_o  (exp_raw),
        .ovf_o  (e_ovf),
        .unf_o  (e_unf)
    );

    // result class, by priority: zero operand, overflow, underflow, normal
    always_comb begin
        if (zero_in)    cls = CLS_ZERO;
        else if (e_ovf) cls = CLS_OVF;
        else if (e_unf) cls = CLS_UNF;
        else            cls = CLS_NORMAL;
    end

    // output stage driven by the class
    always_comb begin
        unique case (cls)
            CLS_NORMAL: begin
                res_o = {sign, exp_raw, frac_n};
                ovf_o = 1'b0;
                unf_o = 1'b0;
            end
            CLS_ZERO: begin
                res_o = {sign, {(W-1){1'b0}}};
                ovf_o = 1'b0;
                unf_o = 1'b0;
            end
            CLS_OVF: begin
                res_o = {sign, EXP_SAT, {FRAC_W{1'b1}}};
                ovf_o = 1'b1;
                unf_o = 1'b0;
            end
            CLS_UNF: begin
                res_o = {sign, {(W-1){1'b0}}};
                ovf_o = 1'b0;
                unf_o = 1'b1;
            end
            default: begin
                res_o = '0;
                ovf_o = 1'b0;
                unf_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        assert_sign_xor_R1: assert (res_o[W-1] == (a_i[W-1] ^ b_i[W-1]));
        assert_flags_excl_R9: assert (!(ovf_o && unf_o));
        assert_prod_nonzero_R3: assert (prod != '0);
        if (zero_in) begin
            assert_zero_no_flags_R8: assert (!ovf_o && !unf_o && res_o[W-2:0] == '0);
        end
        if (ovf_o) begin
            assert_sat_pattern_R6: assert (res_o[W-2:0] == {EXP_SAT, {FRAC_W{1'b1}}});
        end
        if (unf_o) begin
            assert_unf_flush_R7: assert (res_o[W-2:0] == '0);
        end
    end
endmodule

// File: tb/rp_fp_mul_tb.sv
module rp_fp_mul_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] a, b, res;
    logic        ovf, unf;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_fp_mul u_dut (
        .a_i   (a),
        .b_i   (b),
        .res_o (res),
        .ovf_o (ovf),
        .unf_o (unf)
    );

    // behavioural model in integer arithmetic
    task automatic model(input logic [16:0] x, input logic [16:0] y,
                         output logic [16:0] r, output logic o, output logic u,
                         output string tag);
        int ex, ey, p, e, f;
        bit s, n;
        s  = x[16] ^ y[16];
        ex = int'(x[15:8]);
        ey = int'(y[15:8]);
        o  = 1'b0;
        u  = 1'b0;
        if (ex == 0 || ey == 0) begin
            r = {s, 16'h0000};
            tag = "R8";
        end else begin
            p = (256 + int'(x[7:0])) * (256 + int'(y[7:0]));
            n = (p >= 131072);
            f = n ? (p / 512) % 256 : (p / 256) % 256;
            e = ex + ey - 127 + (n ? 1 : 0);
            if (e >= 255) begin
                r = {s, 8'hFE, 8'hFF};
                o = 1'b1;
                tag = "R6";
            end else if (e <= 0) begin
                r = {s, 16'h0000};
                u = 1'b1;
                tag = "R7";
            end else begin
                r = {s, 8'(e), 8'(f)};
                tag = n ? "R4" : "R3";
            end
        end
    endtask

    task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%05h ovf=%0b unf=%0b, expected res=%05h ovf=%0b unf=%0b",
                     tag, got[18:2], got[1], got[0], exp[18:2], exp[1], exp[0]);
        end
    endtask

    // drive one pair just after a rising edge, compare at the falling edge
    task automatic apply(input logic [16:0] x, input logic [16:0] y);
        logic [16:0] r;
        logic o, u;
        string tag;
        @(posedge clk);
        #1;
        a = x;
        b = y;
        model(x, y, r, o, u, tag);
        @(negedge clk);
        check(tag, {res, ovf, unf}, {r, o, u});
        check("R1", {18'b0, res[16]}, {18'b0, x[16] ^ y[16]});
        check("R9", {17'b0, ovf & unf, ~(o | u) & (ovf | unf)}, 19'b0);
    endtask

    task automatic apply_lit(input string tag, input logic [16:0] x, input logic [16:0] y,
                             input logic [16:0] r, input logic o, input logic u);
        @(posedge clk);
        #1;
        a = x;
        b = y;
        @(negedge clk);
        check(tag, {res, ovf, unf}, {r, o, u});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        a = '0;
        b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: zero operands held during reset give a positive zero, no flags
        check("R8", {res, ovf, unf}, 19'b0);
        rst_n = 1'b1;

        // R2: 1.0 * 1.0 lands at exponent 127, fraction 0
        apply_lit("R2", {1'b0, 8'd127, 8'h00}, {1'b0, 8'd127, 8'h00}, 17'h07F00, 1'b0, 1'b0);
        // R5: fraction 8'h81 squared truncates to 8'h21
        apply_lit("R5", {1'b0, 8'd127, 8'h81}, {1'b0, 8'd127, 8'h81}, 17'h08021, 1'b0, 1'b0);
        // R4: 1.5 * -1.5 normalises, exponent 128, fraction 8'h20
        apply_lit("R4", {1'b0, 8'd127, 8'h80}, {1'b1, 8'd127, 8'h80}, 17'h18020, 1'b0, 1'b0);
        // R3: exponent exactly 254 is still finite
        apply_lit("R3", {1'b0, 8'd200, 8'h00}, {1'b0, 8'd181, 8'h00}, 17'h0FE00, 1'b0, 1'b0);
        // R6: the normalisation increment pushes it to 255
        apply_lit("R6", {1'b0, 8'd200, 8'h80}, {1'b0, 8'd181, 8'h80}, 17'h0FEFF, 1'b1, 1'b0);
        // R6: large exponents, negative sign
        apply_lit("R6", {1'b0, 8'd200, 8'h00}, {1'b1, 8'd200, 8'h00}, 17'h1FEFF, 1'b1, 1'b0);
        // R7: adjusted exponent 0 flushes to signed zero
        apply_lit("R7", {1'b1, 8'd60, 8'h00}, {1'b0, 8'd67, 8'h00}, 17'h10000, 1'b0, 1'b1);
        // R4: same exponents with normalisation reach exponent 1
        apply_lit("R4", {1'b1, 8'd60, 8'h80}, {1'b0, 8'd67, 8'h80}, 17'h10120, 1'b0, 1'b0);
        // R8: zero exponent beats a huge partner; no flags
        apply_lit("R8", {1'b1, 8'd0, 8'h55}, {1'b0, 8'd250, 8'hFF}, 17'h10000, 1'b0, 1'b0);
        apply_lit("R8", {1'b0, 8'd250, 8'hFF}, {1'b0, 8'd0, 8'h01}, 17'h00000, 1'b0, 1'b0);

        // arbitrary pairs against the model, one per clock
        for (int i = 0; i < 400; i++) begin
            apply(17'($urandom), 17'($urandom));
        end
        // mid-range exponents to favour normal results
        for (int i = 0; i < 200; i++) begin
            apply({1'($urandom), 8'(64 + ($urandom % 128)), 8'($urandom)},
                  {1'($urandom), 8'(64 + ($urandom % 128)), 8'($urandom)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule